// File: doc/BRIEF.md
# Branch Decision and Next-PC Unit

This unit resolves control transfers for a single-issue core whose branches have one delay slot. Each accepted request carries the address of the branch, two register operands, a small code that names the kind of transfer, a 5-bit bit number, a destination register index and a 16-bit immediate. From these the unit decides whether the transfer is taken. It produces the address the core resumes at once the delay slot has passed. It flags a delay slot that must be squashed, and it describes the register write that a linking form performs.

The supported transfers are register equality and inequality tests, signed tests of one operand against zero, single-bit tests with the bit number taken either from the request or from the second operand, equality tests on one chosen byte lane, register-indirect jumps with and without a link, and a jump within the current 256 MiB region. Every compare branch exists in a plain form. Equality, inequality and the sign tests also have a "likely" form, whose delay slot is squashed when the branch falls through.

A result is registered. It appears one clock after the request is accepted and holds until the next request. The reset input is asserted asynchronously and is released through a two-stage synchronizer inside the unit.

Top module: `nextpc_unit`

## Requirements
- R1: While reset is held, and in the cycle after it releases, out_vld, taken, nullify, link_we, link_idx, link_val and target all read zero.
- R2: A request with in_vld high produces its result one clock later, with out_vld high for exactly that cycle. While in_vld is low, out_vld is low and the other outputs keep their last values.
- R3: The relative branch destination is (pc + 4) + (sign-extended imm16 shifted left by 2). When the transfer is not taken, target is pc + 8.
- R4: Code 1 is taken when rs equals rt, and code 2 is taken when they differ. The likely versions are code 3 (equal) and code 4 (differ).
- R5: The sign branches read rs as a signed 32-bit value. Code 5 is taken if rs < 0 and code 6 if rs >= 0. The likely versions are code 7 (< 0) and code 8 (>= 0).
- R6: Codes 13 and 14 test bit bit_num of rs, being taken when that bit is set (13) or clear (14). Codes 15 and 16 test the bit of rs whose number is rt[4:0], being taken when it is set (15) or clear (16).
- R7: Codes 20 to 23 compare byte lane L = code - 20 of rs and rt, where lane 0 is bits 7:0 and lane 3 is bits 31:24. The branch is taken when the two bytes are equal.
- R8: nullify is high exactly when a likely form (codes 3, 4, 7, 8, 11, 12) is not taken. A taken likely branch and every non-likely code give nullify low.
- R9: Codes 9 (rs < 0), 10 (rs >= 0), 11 (rs < 0, likely) and 12 (rs >= 0, likely) branch and link. When the condition holds they set link_we, link_idx = 31 and link_val = pc + 8. When it fails, link_we is low and link_val is zero.
- R10: Code 17 jumps to rs unchanged. Code 18 jumps to rs unchanged and links pc + 8 into rd_idx. If rd_idx is 0, the link write is suppressed and the jump is still taken.
- R11: Code 19 is always taken, and target = {pc[31:28], 10'b0, imm16, 2'b00}.
- R12: Code 0 and codes 24 to 31 are not transfers. They give taken, nullify and link_we low, and target = pc + 8.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_vld | input | 1 | Request strobe |
| pc | input | 32 | Address of the branch instruction |
| rs_val | input | 32 | First register operand |
| rt_val | input | 32 | Second register operand |
| br_kind | input | 5 | Transfer kind code (see R4 to R12) |
| bit_num | input | 5 | Bit number for the immediate bit tests |
| rd_idx | input | 5 | Link register index for the linking register jump |
| imm16 | input | 16 | Branch offset or region jump field |
| out_vld | output | 1 | Result strobe, one clock after in_vld |
| taken | output | 1 | The transfer redirects the PC |
| target | output | 32 | Address to resume at after the delay slot |
| nullify | output | 1 | Squash the delay slot |
| link_we | output | 1 | Perform a link write |
| link_idx | output | 5 | Register written by the link |
| link_val | output | 32 | Value written by the link |

## Verification
The hardest cases to reach from the ports are the ones where two separate features meet in one request. One is a likely branch-and-link whose condition fails: it must squash the slot and also withhold the link. Another is a variable bit test whose rt value carries set bits above bit 4, which must be ignored. A third is a lane compare where the lanes on either side of the chosen one differ, so that picking the wrong lane changes the answer. The directed tasks build these operand patterns on purpose. One pattern is a sign-bit-only operand, 0x80000000, which is negative under a signed test and would be positive under an unsigned one. Another is an rt of 0x28, whose low five bits name bit 8. A third is an operand pair that agrees in three lanes and differs in one. The tasks then also drop in_vld and change every input, to show that the stored result holds.

// File: rtl/nextpc_pkg.sv
package nextpc_pkg;
  localparam int XLEN     = 32;
  localparam int REGW     = 5;
  localparam int OFFW     = 16;
  localparam int LINK_REG = 31;
  localparam int NLANES   = XLEN / 8;

  typedef enum logic [4:0] {
    K_NONE   = 5'd0,
    K_EQ     = 5'd1,
    K_NE     = 5'd2,
    K_EQ_LK  = 5'd3,
    K_NE_LK  = 5'd4,
    K_LTZ    = 5'd5,
    K_GEZ    = 5'd6,
    K_LTZ_LK = 5'd7,
    K_GEZ_LK = 5'd8,
    K_LTZ_AL = 5'd9,
    K_GEZ_AL = 5'd10,
    K_LTZ_AK = 5'd11,
    K_GEZ_AK = 5'd12,
    K_BSET_I = 5'd13,
    K_BCLR_I = 5'd14,
    K_BSET_V = 5'd15,
    K_BCLR_V = 5'd16,
    K_JREG   = 5'd17,
    K_JREG_L = 5'd18,
    K_JREGN  = 5'd19,
    K_LANE0  = 5'd20,
    K_LANE1  = 5'd21,
    K_LANE2  = 5'd22,
    K_LANE3  = 5'd23
  } br_kind_e;

  typedef struct packed {
    logic            cond;
    logic            likely;
    logic            link31;
    logic            rel;
    logic            jreg;
    logic            jreg_link;
    logic            jregion;
  } br_class_t;

  typedef struct packed {
    logic            taken;
    logic            nullify;
    logic            link_we;
    logic [REGW-1:0] link_idx;
    logic [XLEN-1:0] link_val;
    logic [XLEN-1:0] target;
  } npc_result_t;
endpackage

// File: rtl/nextpc_cond.sv
module nextpc_cond
  import nextpc_pkg::*;
(
  input  br_kind_e        kind,
  input  logic [XLEN-1:0] rs_val,
  input  logic [XLEN-1:0] rt_val,
  input  logic [REGW-1:0] bit_num,
  output br_class_t       cls
);
  localparam int LSELW = $clog2(NLANES);

  logic [NLANES-1:0] lane_eq;
  logic              ops_eq;
  logic              rs_neg;
  logic              bit_imm_set;
  logic              bit_var_set;
  logic [LSELW-1:0]  lane_sel;

  genvar g;
  generate
    for (g = 0; g < NLANES; g++) begin : g_lane
      assign lane_eq[g] = (rs_val[8*g +: 8] == rt_val[8*g +: 8]);
    end
  endgenerate

  assign ops_eq      = (rs_val == rt_val);
  assign rs_neg      = rs_val[XLEN-1];
  assign bit_imm_set = rs_val[bit_num];
  assign bit_var_set = rs_val[rt_val[REGW-1:0]];
  assign lane_sel    = kind[LSELW-1:0];

  always_comb begin
    cls = '0;
    case (kind)
      K_EQ:     begin cls.rel = 1'b1; cls.cond = ops_eq;  end
      K_NE:     begin cls.rel = 1'b1; cls.cond = !ops_eq; end
      K_EQ_LK:  begin cls.rel = 1'b1; cls.likely = 1'b1; cls.cond = ops_eq;  end
      K_NE_LK:  begin cls.rel = 1'b1; cls.likely = 1'b1; cls.cond = !ops_eq; end
      K_LTZ:    begin cls.rel = 1'b1; cls.cond = rs_neg;  end
      K_GEZ:    begin cls.rel = 1'b1; cls.cond = !rs_neg; end
      K_LTZ_LK: begin cls.rel = 1'b1; cls.likely = 1'b1; cls.cond = rs_neg;  end
      K_GEZ_LK: begin cls.rel = 1'b1; cls.likely = 1'b1; cls.cond = !rs_neg; end
      K_LTZ_AL: begin cls.rel = 1'b1; cls.link31 = 1'b1; cls.cond = rs_neg;  end
      K_GEZ_AL: begin cls.rel = 1'b1; cls.link31 = 1'b1; cls.cond = !rs_neg; end
      K_LTZ_AK: begin
        cls.rel = 1'b1; cls.link31 = 1'b1; cls.likely = 1'b1; cls.cond = rs_neg;
      end
      K_GEZ_AK: begin
        cls.rel = 1'b1; cls.link31 = 1'b1; cls.likely = 1'b1; cls.cond = !rs_neg;
      end
      K_BSET_I: begin cls.rel = 1'b1; cls.cond = bit_imm_set;  end
      K_BCLR_I: begin cls.rel = 1'b1; cls.cond = !bit_imm_set; end
      K_BSET_V: begin cls.rel = 1'b1; cls.cond = bit_var_set;  end
      K_BCLR_V: begin cls.rel = 1'b1; cls.cond = !bit_var_set; end
      K_JREG:   begin cls.jreg = 1'b1; cls.cond = 1'b1; end
      K_JREG_L: begin cls.jreg = 1'b1; cls.jreg_link = 1'b1; cls.cond = 1'b1; end
      K_JREGN:  begin cls.jregion = 1'b1; cls.cond = 1'b1; end
      K_LANE0, K_LANE1, K_LANE2, K_LANE3: begin
        cls.rel  = 1'b1;
        cls.cond = lane_eq[lane_sel];
      end
      default:  cls = '0;
    endcase
  end
endmodule

// File: rtl/nextpc_target.sv
module nextpc_target
  import nextpc_pkg::*;
(
  input  logic [XLEN-1:0] pc,
  input  logic [XLEN-1:0] rs_val,
  input  logic [OFFW-1:0] imm16,
  input  br_class_t       cls,
  output logic [XLEN-1:0] seq_pc,
  output logic [XLEN-1:0] dest_pc
);
  localparam int PADW = XLEN - OFFW - 2;
  localparam int REGION_BITS = 4;
  localparam int ZPADW = XLEN - REGION_BITS - OFFW - 2;

  logic [XLEN-1:0] slot_pc;
  logic [XLEN-1:0] off_ext;
  logic [XLEN-1:0] rel_pc;
  logic [XLEN-1:0] region_pc;

  assign slot_pc   = pc + XLEN'(4);
  assign seq_pc    = pc + XLEN'(8);
  assign off_ext   = {{PADW{imm16[OFFW-1]}}, imm16, 2'b00};
  assign rel_pc    = slot_pc + off_ext;
  assign region_pc = {pc[XLEN-1 -: REGION_BITS], {ZPADW{1'b0}}, imm16, 2'b00};

  always_comb begin
    if (cls.jreg)         dest_pc = rs_val;
    else if (cls.jregion) dest_pc = region_pc;
    else                  dest_pc = rel_pc;
  end
endmodule

// File: rtl/nextpc_link.sv
module nextpc_link
  import nextpc_pkg::*;
(
  input  br_class_t       cls,
  input  logic [REGW-1:0] rd_idx,
  input  logic [XLEN-1:0] seq_pc,
  output logic            link_we,
  output logic [REGW-1:0] link_idx,
  output logic [XLEN-1:0] link_val
);
  logic want31;
  logic want_rd;

  assign want31  = cls.link31 && cls.cond;
  assign want_rd = cls.jreg_link && (rd_idx != '0);

  always_comb begin
    link_we  = want31 || want_rd;
    link_idx = '0;
    link_val = '0;
    if (want_rd) begin
      link_idx = rd_idx;
      link_val = seq_pc;
    end else if (want31) begin
      link_idx = REGW'(LINK_REG);
      link_val = seq_pc;
    end
  end
endmodule

// File: rtl/nextpc_unit.sv
module nextpc_unit
  import nextpc_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        in_vld,
  input  logic [31:0] pc,
  input  logic [31:0] rs_val,
  input  logic [31:0] rt_val,
  input  logic [4:0]  br_kind,
  input  logic [4:0]  bit_num,
  input  logic [4:0]  rd_idx,
  input  logic [15:0] imm16,
  output logic        out_vld,
  output logic        taken,
  output logic [31:0] target,
  output logic        nullify,
  output logic        link_we,
  output logic [4:0]  link_idx,
  output logic [31:0] link_val
);
  logic rst_meta_q;
  logic rst_sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_q <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_q <= rst_meta_q;
    end
  end

  br_kind_e        kind;
  br_class_t       cls;
  logic [XLEN-1:0] seq_pc;
  logic [XLEN-1:0] dest_pc;
  logic            lk_we;
  logic [REGW-1:0] lk_idx;
  logic [XLEN-1:0] lk_val;
  npc_result_t     res_d;
  npc_result_t     res_q;
  logic            vld_q;

  assign kind = br_kind_e'(br_kind);

  nextpc_cond u_cond (
    .kind    (kind),
    .rs_val  (rs_val),
    .rt_val  (rt_val),
    .bit_num (bit_num),
    .cls     (cls)
  );

  nextpc_target u_target (
    .pc      (pc),
    .rs_val  (rs_val),
    .imm16   (imm16),
    .cls     (cls),
    .seq_pc  (seq_pc),
    .dest_pc (dest_pc)
  );

  nextpc_link u_link (
    .cls      (cls),
    .rd_idx   (rd_idx),
    .seq_pc   (seq_pc),
    .link_we  (lk_we),
    .link_idx (lk_idx),
    .link_val (lk_val)
  );

  always_comb begin
    res_d          = '0;
    res_d.taken    = cls.cond;
    res_d.nullify  = cls.likely && !cls.cond;
    res_d.target   = cls.cond ? dest_pc : seq_pc;
    res_d.link_we  = lk_we;
    res_d.link_idx = lk_idx;
    res_d.link_val = lk_val;
  end

  always_ff @(posedge clk or negedge rst_sync_q) begin
    if (!rst_sync_q) begin
      vld_q <= 1'b0;
      res_q <= '0;
    end else begin
      vld_q <= in_vld;
      if (in_vld) begin
        res_q <= res_d;
      end
    end
  end

  assign out_vld  = vld_q;
  assign taken    = res_q.taken;
  assign nullify  = res_q.nullify;
  assign target   = res_q.target;
  assign link_we  = res_q.link_we;
  assign link_idx = res_q.link_idx;
  assign link_val = res_q.link_val;

  p_nullify_excl_r8: assert property (@(posedge clk) disable iff (!rst_sync_q)
    (out_vld && nullify) |-> !taken)
    else $error("nullify together with taken");

  p_link_nonzero_r10: assert property (@(posedge clk) disable iff (!rst_sync_q)
    link_we |-> (link_idx != 5'd0))
    else $error("link write to register 0");

  p_hold_r2: assert property (@(posedge clk) disable iff (!rst_sync_q)
    !in_vld |=> ($stable(target) && $stable(taken) && $stable(nullify) &&
                 $stable(link_we) && $stable(link_val) && !out_vld))
    else $error("result changed without a request");

  p_seq_r3: assert property (@(posedge clk) disable iff (!rst_sync_q)
    (out_vld && !taken) |-> (target == $past(pc) + 32'd8))
    else $error("fall-through address wrong");

  p_region_r11: assert property (@(posedge clk) disable iff (!rst_sync_q)
    (out_vld && $past(br_kind) == 5'd19) |-> (taken && target[31:28] == $past(pc[31:28])))
    else $error("region jump lost PC top bits");

  p_link_val_r9: assert property (@(posedge clk) disable iff (!rst_sync_q)
    (out_vld && link_we) |-> (link_val == $past(pc) + 32'd8))
    else $error("link value wrong");
endmodule

// File: tb/nextpc_unit_tb_top.sv
`timescale 1ns/1ps
module nextpc_unit_tb_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        in_vld;
  logic [31:0] pc, rs_val, rt_val;
  logic [4:0]  br_kind, bit_num, rd_idx;
  logic [15:0] imm16;
  logic        out_vld, taken, nullify, link_we;
  logic [31:0] target, link_val;
  logic [4:0]  link_idx;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #4 clk = ~clk;

  nextpc_unit dut_i (
    .clk(clk), .rst_n(rst_n), .in_vld(in_vld), .pc(pc), .rs_val(rs_val),
    .rt_val(rt_val), .br_kind(br_kind), .bit_num(bit_num), .rd_idx(rd_idx),
    .imm16(imm16), .out_vld(out_vld), .taken(taken), .target(target),
    .nullify(nullify), .link_we(link_we), .link_idx(link_idx), .link_val(link_val)
  );

  task automatic chk(input string req, input string what, input logic [31:0] act,
                     input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual 0x%08h expected 0x%08h", req, what, act, exp);
    end
  endtask

  // drive at a falling edge, the result registers at the next rising edge,
  // sample at the falling edge that follows
  task automatic issue(input logic [4:0] k, input logic [31:0] p, input logic [31:0] a,
                       input logic [31:0] b, input logic [4:0] bn, input logic [4:0] rd,
                       input logic [15:0] im);
    @(negedge clk);
    in_vld = 1'b1; br_kind = k; pc = p; rs_val = a; rt_val = b;
    bit_num = bn; rd_idx = rd; imm16 = im;
    @(negedge clk);
    in_vld = 1'b0;
  endtask

  task automatic expect_res(input string req, input logic t, input logic [31:0] tg,
                            input logic nl, input logic we, input logic [4:0] li,
                            input logic [31:0] lv);
    chk(req, "out_vld", {31'b0, out_vld}, 32'd1);
    chk(req, "taken", {31'b0, taken}, {31'b0, t});
    chk(req, "target", target, tg);
    chk(req, "nullify", {31'b0, nullify}, {31'b0, nl});
    chk(req, "link_we", {31'b0, link_we}, {31'b0, we});
    chk(req, "link_idx", {27'b0, link_idx}, {27'b0, li});
    chk(req, "link_val", link_val, lv);
  endtask

  task automatic t_reset();
    chk("R1", "out_vld", {31'b0, out_vld}, 32'd0);
    chk("R1", "taken", {31'b0, taken}, 32'd0);
    chk("R1", "target", target, 32'd0);
    chk("R1", "nullify", {31'b0, nullify}, 32'd0);
    chk("R1", "link_we", {31'b0, link_we}, 32'd0);
    chk("R1", "link_val", link_val, 32'd0);
  endtask

  task automatic t_compare();
    issue(5'd1, 32'h1000, 32'd5, 32'd5, 5'd0, 5'd0, 16'h0010);
    expect_res("R4 beq taken (R3)", 1, 32'h1044, 0, 0, 0, 0);
    issue(5'd2, 32'h1000, 32'd5, 32'd5, 5'd0, 5'd0, 16'h0010);
    expect_res("R4 bne fall (R3)", 0, 32'h1008, 0, 0, 0, 0);
    issue(5'd2, 32'h1000, 32'd1, 32'd2, 5'd0, 5'd0, 16'hFFFE);
    expect_res("R3 negative offset", 1, 32'h0FFC, 0, 0, 0, 0);
  endtask

  task automatic t_sign();
    issue(5'd5, 32'h2000, 32'h80000000, 32'h0, 5'd0, 5'd0, 16'h0001);
    expect_res("R5 ltz min", 1, 32'h2008, 0, 0, 0, 0);
    issue(5'd6, 32'h2000, 32'h80000000, 32'h0, 5'd0, 5'd0, 16'h0001);
    expect_res("R5 gez min", 0, 32'h2008, 0, 0, 0, 0);
    issue(5'd6, 32'h2000, 32'h0, 32'h0, 5'd0, 5'd0, 16'h0002);
    expect_res("R5 gez zero", 1, 32'h200C, 0, 0, 0, 0);
    issue(5'd5, 32'h2000, 32'h7FFFFFFF, 32'h0, 5'd0, 5'd0, 16'h0002);
    expect_res("R5 ltz max", 0, 32'h2008, 0, 0, 0, 0);
  endtask

  task automatic t_bits();
    issue(5'd13, 32'h3000, 32'h00000100, 32'h0, 5'd8, 5'd0, 16'h0004);
    expect_res("R6 bset imm hit", 1, 32'h3014, 0, 0, 0, 0);
    issue(5'd13, 32'h3000, 32'h00000100, 32'h0, 5'd7, 5'd0, 16'h0004);
    expect_res("R6 bset imm miss", 0, 32'h3008, 0, 0, 0, 0);
    issue(5'd14, 32'h3000, 32'h00000100, 32'h0, 5'd7, 5'd0, 16'h0004);
    expect_res("R6 bclr imm", 1, 32'h3014, 0, 0, 0, 0);
    issue(5'd15, 32'h3000, 32'h00000100, 32'h00000028, 5'd0, 5'd0, 16'h0004);
    expect_res("R6 bset var masked", 1, 32'h3014, 0, 0, 0, 0);
    issue(5'd16, 32'h3000, 32'h00000100, 32'h00000028, 5'd0, 5'd0, 16'h0004);
    expect_res("R6 bclr var", 0, 32'h3008, 0, 0, 0, 0);
  endtask

  task automatic t_lanes();
    issue(5'd20, 32'h4000, 32'h11223344, 32'h11AA3344, 5'd0, 5'd0, 16'h0001);
    expect_res("R7 lane0", 1, 32'h4008, 0, 0, 0, 0);
    issue(5'd21, 32'h4000, 32'h11223344, 32'h11AA3344, 5'd0, 5'd0, 16'h0001);
    expect_res("R7 lane1", 1, 32'h4008, 0, 0, 0, 0);
    issue(5'd22, 32'h4000, 32'h11223344, 32'h11AA3344, 5'd0, 5'd0, 16'h0003);
    expect_res("R7 lane2 differs", 0, 32'h4008, 0, 0, 0, 0);
    issue(5'd23, 32'h4000, 32'h11223344, 32'h11AA3344, 5'd0, 5'd0, 16'h0003);
    expect_res("R7 lane3", 1, 32'h4010, 0, 0, 0, 0);
  endtask

  task automatic t_likely();
    issue(5'd3, 32'h5000, 32'd1, 32'd2, 5'd0, 5'd0, 16'h0008);
    expect_res("R8 beql fall", 0, 32'h5008, 1, 0, 0, 0);
    issue(5'd3, 32'h5000, 32'd2, 32'd2, 5'd0, 5'd0, 16'h0008);
    expect_res("R8 beql taken", 1, 32'h5024, 0, 0, 0, 0);
    issue(5'd4, 32'h5000, 32'd2, 32'd2, 5'd0, 5'd0, 16'h0008);
    expect_res("R8 bnel fall", 0, 32'h5008, 1, 0, 0, 0);
    issue(5'd8, 32'h5000, 32'hFFFFFFFF, 32'd0, 5'd0, 5'd0, 16'h0008);
    expect_res("R8 gezl fall", 0, 32'h5008, 1, 0, 0, 0);
    issue(5'd7, 32'h5000, 32'hFFFFFFFF, 32'd0, 5'd0, 5'd0, 16'h0008);
    expect_res("R8 ltzl taken", 1, 32'h5024, 0, 0, 0, 0);
  endtask

  task automatic t_link();
    issue(5'd9, 32'h6000, 32'hFFFFFFFF, 32'd0, 5'd0, 5'd0, 16'h0002);
    expect_res("R9 ltzal taken", 1, 32'h600C, 0, 1, 5'd31, 32'h6008);
    issue(5'd9, 32'h6000, 32'd1, 32'd0, 5'd0, 5'd0, 16'h0002);
    expect_res("R9 ltzal fall", 0, 32'h6008, 0, 0, 0, 0);
    issue(5'd12, 32'h6000, 32'hFFFFFFFF, 32'd0, 5'd0, 5'd0, 16'h0002);
    expect_res("R9 gezall fall", 0, 32'h6008, 1, 0, 0, 0);
    issue(5'd10, 32'h6100, 32'd0, 32'd0, 5'd0, 5'd0, 16'h0002);
    expect_res("R9 gezal taken", 1, 32'h610C, 0, 1, 5'd31, 32'h6108);
  endtask

  task automatic t_jumps();
    issue(5'd17, 32'h7000, 32'h12345679, 32'd0, 5'd0, 5'd7, 16'h0000);
    expect_res("R10 jr", 1, 32'h12345679, 0, 0, 0, 0);
    issue(5'd18, 32'h7000, 32'h00008000, 32'd0, 5'd0, 5'd7, 16'h0000);
    expect_res("R10 jalr rd7", 1, 32'h00008000, 0, 1, 5'd7, 32'h7008);
    issue(5'd18, 32'h7000, 32'h00008000, 32'd0, 5'd0, 5'd0, 16'h0000);
    expect_res("R10 jalr rd0", 1, 32'h00008000, 0, 0, 0, 0);
    issue(5'd19, 32'hA0001000, 32'hFFFFFFFF, 32'd0, 5'd0, 5'd0, 16'h1234);
    expect_res("R11 region jump", 1, 32'hA00048D0, 0, 0, 0, 0);
  endtask

  task automatic t_unknown();
    issue(5'd0, 32'h8000, 32'd3, 32'd3, 5'd0, 5'd5, 16'h0010);
    expect_res("R12 code0", 0, 32'h8008, 0, 0, 0, 0);
    issue(5'd25, 32'h8000, 32'd3, 32'd3, 5'd0, 5'd5, 16'h0010);
    expect_res("R12 code25", 0, 32'h8008, 0, 0, 0, 0);
  endtask

  task automatic t_hold();
    issue(5'd9, 32'h9000, 32'hFFFFFFFF, 32'd0, 5'd0, 5'd0, 16'h0001);
    @(negedge clk);
    pc = 32'h0; rs_val = 32'h1; br_kind = 5'd2; rd_idx = 5'd3;
    @(negedge clk);
    @(negedge clk);
    chk("R2", "out_vld low", {31'b0, out_vld}, 32'd0);
    chk("R2", "held target", target, 32'h9008);
    chk("R2", "held link", link_val, 32'h9008);
    chk("R2", "held taken", {31'b0, taken}, 32'd1);
  endtask

  initial begin
    rst_n = 1'b0; in_vld = 1'b0; pc = '0; rs_val = '0; rt_val = '0;
    br_kind = '0; bit_num = '0; rd_idx = '0; imm16 = '0;
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    repeat (2) @(negedge clk);
    t_compare();
    t_sign();
    t_bits();
    t_lanes();
    t_likely();
    t_link();
    t_jumps();
    t_unknown();
    t_hold();
    done = 1'b1;
  end

  initial begin : watchdog
    fork
      begin wait (done); end
      begin
        repeat (20000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual hung expected done");
      end
    join_any
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule